// File: doc/BRIEF.md
# Link Reset Handshake Sequencer

This block watches the link-reset flag reported by a USB bridge in a 32-bit status word and runs a fixed recovery sequence each time that flag changes. The bridge engine, the data FIFOs and the DMA engine sit outside the block. They appear only as command pulses leaving the block and busy flags coming back.

The block keeps the last reset level it has seen.

- **Reset asserted.** The block first signals completion of any pending packet and any transmit in progress. It then stops the DMA engine and waits for DMA to go idle. Next it flushes the FIFOs and waits for the flush to finish. Finally it requests a write-buffer flush and acknowledges reset entry.
- **Reset released.** The block gives only the reset-exit acknowledge.
- **After a block reset.** The block runs the DMA-stop and FIFO-flush drain once, with no acknowledge.

Each wait has a programmable timeout. A timeout raises a sticky error and abandons the sequence. The block also reports whether the link is active.

Top module: `link_rst_seq`

## Requirements
- R1: While `rst` is high and in the cycle after it, every pulse output is low, `link_active` is low and `tmo_err` is low.
- R2: After `rst` falls, the block runs one drain before anything else: a `dma_stop` pulse, a wait until `dma_busy` is low, a FIFO-flush pulse, and a wait until flush-busy is low. This drain issues no acknowledge and no write-buffer flush.
- R3: The block starts a sequence only in an idle cycle where the reset flag differs from the stored level, and it stores the new level in that cycle. A steady reset flag, at either level, produces no pulse.
- R4: After a rise of the reset flag, the pulses follow in this order, one stage per cycle:
  - a completion stage, then a transmit stage;
  - `dma_stop`, then a wait on `dma_busy`;
  - FIFO flush, then a wait on flush-busy;
  - write-buffer flush, then the reset-entry acknowledge.
- R5: After a fall of the reset flag, the only pulse is the reset-exit acknowledge, given in the cycle after the change is seen.
- R6: `link_active` is high only when all of the following hold:
  - the block is idle;
  - no post-reset drain is pending;
  - the reset flag equals the stored level;
  - the reset flag and the power-save flag are both low.
- R7: Every pulse output is high for a single cycle, and at most one of them is high in any cycle.
- R8: If a busy flag is still high when a wait has lasted `tmo_limit`+1 cycles, `tmo_err` goes high and stays high until `rst`. The block returns to idle and gives no acknowledge.
- R9: `ctrl_pulse` carries FIFO flush in bit 0, the entry acknowledge in bit 3, the exit acknowledge in bit 4 and the write-buffer flush in bit 5. Bits 1 and 2 are always 0. In `status_word`, bit 28 is the reset flag, bit 29 is power-save and bit 30 is flush-busy. All other status bits are ignored.
- R10: `pkt_done` pulses in the completion stage only if `pkt_pending` is high. `tx_done` pulses in the transmit stage only if `tx_active` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| status_word | input | 32 | Status word: reset flag in bit 28, power-save in bit 29, flush-busy in bit 30 |
| dma_busy | input | 1 | DMA engine still running |
| pkt_pending | input | 1 | A packet awaits its completion signal |
| tx_active | input | 1 | A transmit is in progress |
| tmo_limit | input | TMO_W | Wait timeout limit, in cycles |
| ctrl_pulse | output | 6 | Control-word pulses: flush, entry ack, exit ack, write flush |
| dma_stop | output | 1 | Stop pulse to the DMA engine |
| pkt_done | output | 1 | Packet completion pulse |
| tx_done | output | 1 | Transmit completion pulse |
| link_active | output | 1 | Link usable |
| tmo_err | output | 1 | Sticky wait-timeout error |

## Verification
The sequencer is counted from the idle cycle in which it sees a change of the reset flag (call it cycle 0):

| Cycle | Reset rise | Reset fall |
|---|---|---|
| 0 | change seen, `link_active` already low | change seen, `link_active` already low |
| 1 | completion stage | exit acknowledge |
| 2 | transmit stage | — |
| 3 | `dma_stop` | — |

On the rise path, each flush pulse comes one cycle after the cycle in which its wait sees the busy flag low. The entry acknowledge follows the write-buffer flush directly.

The bench holds a queue of expected stages and moves it forward once per clock, using the same inputs the design sees. All outputs are compared at the falling edge, after the inputs have settled and before the next rising edge. Every cycle-exact position is therefore checked, including the timeout cycle, with no tolerance window.

// File: rtl/link_rst_seq.sv
module link_rst_seq #(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [31:0]      status_word,
  input  logic             dma_busy,
  input  logic             pkt_pending,
  input  logic             tx_active,
  input  logic [TMO_W-1:0] tmo_limit,
  output logic [5:0]       ctrl_pulse,
  output logic             dma_stop,
  output logic             pkt_done,
  output logic             tx_done,
  output logic             link_active,
  output logic             tmo_err
);
  localparam int RS_BIT  = 28;
  localparam int PS_BIT  = 29;
  localparam int FB_BIT  = 30;
  localparam int C_FLUSH = 0;
  localparam int C_ON    = 3;
  localparam int C_OFF   = 4;
  localparam int C_WR    = 5;

  typedef enum logic [3:0] {
    S_IDLE, S_PKT, S_TX, S_DSTOP, S_DWAIT, S_FFL, S_FWAIT, S_WRFL, S_ONACK, S_OFFACK
  } st_t;

  st_t              st;
  logic             init_pend, last_rs, entry;
  logic [TMO_W-1:0] cnt;

  wire rs    = status_word[RS_BIT];
  wire ps    = status_word[PS_BIT];
  wire fbusy = status_word[FB_BIT];
  wire chg   = rs != last_rs;

  logic unused_status;
  assign unused_status = ^{status_word[31], status_word[27:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      init_pend <= 1'b1;
      last_rs   <= 1'b0;
      entry     <= 1'b0;
      tmo_err   <= 1'b0;
      cnt       <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          cnt <= '0;
          if (init_pend) begin
            init_pend <= 1'b0;
            entry     <= 1'b0;
            st        <= S_DSTOP;
          end else if (chg) begin
            last_rs <= rs;
            entry   <= rs;
            st      <= rs ? S_PKT : S_OFFACK;
          end
        end
        S_PKT:   st <= S_TX;
        S_TX:    st <= S_DSTOP;
        S_DSTOP: st <= S_DWAIT;
        S_DWAIT: begin
          if (!dma_busy) begin
            st  <= S_FFL;
            cnt <= '0;
          end else if (cnt == tmo_limit) begin
            tmo_err <= 1'b1;
            st      <= S_IDLE;
            cnt     <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_FFL:   st <= S_FWAIT;
        S_FWAIT: begin
          if (!fbusy) begin
            st  <= entry ? S_WRFL : S_IDLE;
            cnt <= '0;
          end else if (cnt == tmo_limit) begin
            tmo_err <= 1'b1;
            st      <= S_IDLE;
            cnt     <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_WRFL:  st <= S_ONACK;
        S_ONACK: st <= S_IDLE;
        S_OFFACK: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    ctrl_pulse          = '0;
    ctrl_pulse[C_FLUSH] = st == S_FFL;
    ctrl_pulse[C_ON]    = st == S_ONACK;
    ctrl_pulse[C_OFF]   = st == S_OFFACK;
    ctrl_pulse[C_WR]    = st == S_WRFL;
  end

  assign dma_stop    = st == S_DSTOP;
  assign pkt_done    = (st == S_PKT) && pkt_pending;
  assign tx_done     = (st == S_TX) && tx_active;
  assign link_active = (st == S_IDLE) && !init_pend && !chg && !rs && !ps;
endmodule

module link_rst_seq_chk (
  input logic        clk,
  input logic        rst,
  input logic [31:0] status_word,
  input logic        pkt_pending,
  input logic        tx_active,
  input logic [5:0]  ctrl_pulse,
  input logic        dma_stop,
  input logic        pkt_done,
  input logic        tx_done,
  input logic        link_active,
  input logic        tmo_err
);
  wire [8:0] all_p = {ctrl_pulse, dma_stop, pkt_done, tx_done};

  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (all_p == '0 && !link_active && !tmo_err));

  a_r7_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(all_p));

  a_r7_single: assert property (@(posedge clk) disable iff (rst)
    (all_p != '0) |=> ((all_p & $past(all_p)) == '0));

  a_r4_ack_after_wrflush: assert property (@(posedge clk) disable iff (rst)
    ctrl_pulse[3] |-> $past(ctrl_pulse[5]));

  a_r6_active_flags: assert property (@(posedge clk) disable iff (rst)
    link_active |-> (!status_word[28] && !status_word[29]));

  a_r8_err_sticky: assert property (@(posedge clk) disable iff (rst)
    tmo_err |=> tmo_err);

  a_r9_unused_bits: assert property (@(posedge clk) disable iff (rst)
    ctrl_pulse[2:1] == 2'b00);

  a_r10_pkt_only_pending: assert property (@(posedge clk) disable iff (rst)
    pkt_done |-> pkt_pending);

  a_r10_tx_only_active: assert property (@(posedge clk) disable iff (rst)
    tx_done |-> tx_active);
endmodule

bind link_rst_seq link_rst_seq_chk u_chk (
  .clk(clk), .rst(rst), .status_word(status_word), .pkt_pending(pkt_pending),
  .tx_active(tx_active), .ctrl_pulse(ctrl_pulse), .dma_stop(dma_stop),
  .pkt_done(pkt_done), .tx_done(tx_done), .link_active(link_active), .tmo_err(tmo_err)
);

// File: tb/test_link_rst_seq.sv
module test_link_rst_seq;
  localparam int CLK_PERIOD = 10;
  localparam int TW = 16;

  localparam int OP_PKT = 1, OP_TX = 2, OP_DMA = 3, OP_WD = 4, OP_FL = 5,
                 OP_WF = 6, OP_WR = 7, OP_ON = 8, OP_OFF = 9;

  logic clk = 0, rst = 1;
  logic rs = 0, ps = 0, pkt_pending = 0, tx_active = 0;
  logic [TW-1:0] tmo_limit = 16'd20;
  int dma_lat = 3, fl_lat = 2;
  int dcnt = 0, fcnt = 0;
  logic dma_busy, fbusy;
  logic [31:0] status_word;
  logic [5:0] ctrl_pulse;
  logic dma_stop, pkt_done, tx_done, link_active, tmo_err;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign dma_busy = dcnt != 0;
  assign fbusy = fcnt != 0;
  assign status_word = {1'b1, fbusy, ps, rs, 28'h5A5A5A5};

  link_rst_seq #(.TMO_W(TW)) i_link_rst_seq (
    .clk(clk), .rst(rst), .status_word(status_word), .dma_busy(dma_busy),
    .pkt_pending(pkt_pending), .tx_active(tx_active), .tmo_limit(tmo_limit),
    .ctrl_pulse(ctrl_pulse), .dma_stop(dma_stop), .pkt_done(pkt_done),
    .tx_done(tx_done), .link_active(link_active), .tmo_err(tmo_err)
  );

  always @(posedge clk) begin
    if (dma_stop) dcnt <= dma_lat; else if (dcnt > 0) dcnt <= dcnt - 1;
    if (ctrl_pulse[0]) fcnt <= fl_lat; else if (fcnt > 0) fcnt <= fcnt - 1;
  end

  int checks = 0, fails = 0, cyc = 0;
  int q[$];
  bit mvalid = 0, m_init = 0, m_last = 0, m_err = 0;
  int m_cnt = 0;
  int n_dma = 0, n_fl = 0, n_on = 0, n_off = 0, n_wr = 0, n_pkt = 0, n_tx = 0, n_any = 0, n_multi = 0;

  task automatic chk(string req, string nm, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, nm, act, exp);
    end
  endtask

  task automatic clr_counts();
    n_dma = 0; n_fl = 0; n_on = 0; n_off = 0; n_wr = 0; n_pkt = 0; n_tx = 0; n_any = 0; n_multi = 0;
  endtask

  always @(negedge clk) begin
    logic [5:0] e_ctrl;
    logic e_dma, e_pkt, e_tx, e_act;
    int op, np;
    cyc++;
    np = $countones({ctrl_pulse, dma_stop, pkt_done, tx_done});
    if (np > 0) n_any++;
    if (np > 1) n_multi++;
    n_dma += dma_stop; n_fl += ctrl_pulse[0]; n_on += ctrl_pulse[3];
    n_off += ctrl_pulse[4]; n_wr += ctrl_pulse[5]; n_pkt += pkt_done; n_tx += tx_done;
    e_ctrl = '0; e_dma = 0; e_pkt = 0; e_tx = 0; e_act = 0;
    op = (q.size() > 0) ? q[0] : 0;
    case (op)
      0: e_act = !m_init && (rs == m_last) && !rs && !ps;
      OP_PKT: e_pkt = pkt_pending;
      OP_TX: e_tx = tx_active;
      OP_DMA: e_dma = 1;
      OP_FL: e_ctrl[0] = 1;
      OP_WR: e_ctrl[5] = 1;
      OP_ON: e_ctrl[3] = 1;
      OP_OFF: e_ctrl[4] = 1;
      default: ;
    endcase
    if (mvalid) begin
      chk("R9", "ctrl_pulse", {26'd0, ctrl_pulse}, {26'd0, e_ctrl});
      chk("R4", "dma_stop", {31'd0, dma_stop}, {31'd0, e_dma});
      chk("R10", "pkt_done", {31'd0, pkt_done}, {31'd0, e_pkt});
      chk("R10", "tx_done", {31'd0, tx_done}, {31'd0, e_tx});
      chk("R6", "link_active", {31'd0, link_active}, {31'd0, e_act});
      chk("R8", "tmo_err", {31'd0, tmo_err}, {31'd0, m_err});
    end
    if (rst) begin
      q.delete(); m_init = 1; m_last = 0; m_err = 0; m_cnt = 0; mvalid = 1;
    end else if (op == 0) begin
      if (m_init) begin
        m_init = 0; q = '{OP_DMA, OP_WD, OP_FL, OP_WF};
      end else if (rs != m_last) begin
        m_last = rs;
        if (rs) q = '{OP_PKT, OP_TX, OP_DMA, OP_WD, OP_FL, OP_WF, OP_WR, OP_ON};
        else q = '{OP_OFF};
      end
    end else if (op == OP_WD || op == OP_WF) begin
      if (!((op == OP_WD) ? dma_busy : fbusy)) begin
        void'(q.pop_front()); m_cnt = 0;
      end else if (m_cnt == int'(tmo_limit)) begin
        m_err = 1; q.delete(); m_cnt = 0;
      end else m_cnt++;
    end else void'(q.pop_front());
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    step(3);
    chk("R1", "link_active in reset", {31'd0, link_active}, 0);
    chk("R1", "no pulse in reset", n_any, 0);
    rst = 0;
    clr_counts();
    step(20);
    chk("R2", "init dma stops", n_dma, 1);
    chk("R2", "init fifo flushes", n_fl, 1);
    chk("R2", "init no ack/wr", n_on + n_off + n_wr, 0);
    clr_counts();
    step(10);
    chk("R3", "steady low no pulses", n_any, 0);
    chk("R6", "active when idle", {31'd0, link_active}, 1);
    ps = 1; step(2);
    chk("R6", "power-save inactive", {31'd0, link_active}, 0);
    ps = 0;
    pkt_pending = 1; tx_active = 1; dma_lat = 4; fl_lat = 3;
    clr_counts();
    rs = 1; step(30);
    chk("R4", "entry on ack", n_on, 1);
    chk("R4", "entry write flush", n_wr, 1);
    chk("R10", "pkt done once", n_pkt, 1);
    chk("R10", "tx done once", n_tx, 1);
    chk("R7", "no overlap", n_multi, 0);
    clr_counts();
    step(10);
    chk("R3", "steady high no pulses", n_any, 0);
    pkt_pending = 0; tx_active = 0;
    rs = 0; step(6);
    chk("R5", "exit only off ack", n_off, 1);
    chk("R5", "exit nothing else", n_any, 1);
    clr_counts();
    rs = 1; dma_lat = 0; fl_lat = 0; step(20);
    chk("R10", "no pkt when idle", n_pkt + n_tx, 0);
    chk("R4", "entry zero latency ack", n_on, 1);
    rs = 0; step(6);
    clr_counts();
    tmo_limit = 16'd5; dma_lat = 50;
    rs = 1; step(20);
    chk("R8", "timeout error", {31'd0, tmo_err}, 1);
    chk("R8", "no ack on timeout", n_on, 0);
    step(60);
    chk("R8", "error sticky", {31'd0, tmo_err}, 1);
    rst = 1; step(2);
    chk("R1", "reset clears err", {31'd0, tmo_err}, 0);
    rst = 0; rs = 0; dma_lat = 2; fl_lat = 2; tmo_limit = 16'd20;
    step(20);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule